// File: doc/BRIEF.md
# Double-Precision to 64-bit Integer Converter

This block turns a 64-bit IEEE binary64 value into a 64-bit two's-complement integer in one registered step. A caller presents the operand, a two-bit rounding mode and a report enable, and pulses a start strobe. One clock later the integer appears with a valid pulse, together with three flags: invalid, overflow and inexact.

The conversion does not saturate. When the value does not fit, the output is the low 64 bits of the rounded magnitude, negated if the operand is negative. This wrapped pattern lets the same path serve unsigned conversions too. Rounding uses a 64-bit word that holds the discarded fraction bits aligned to its top, plus a sticky one when every bit falls off. Trapping on the flags is the caller's job.

Top module: `dbl2int_conv`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `start_i` high. Without a start, the result and the flags hold their previous values.
- R2: A zero operand of either sign gives result 0 with all three flags low.
- R3: An exponent field of all ones gives result 0. A nonzero fraction (NaN) raises `invalid_o` whether or not reporting is enabled. A zero fraction (infinity) raises `overflow_o` only when `report_en_i` is 1.
- R4: A zero exponent with a nonzero fraction (subnormal) has integer part 0 and a sticky discarded value. It raises `inexact_o` when reporting is enabled and rounds by mode: up gives 1 for a positive value, and down gives -1 (all ones) for a negative value.
- R5: With the hidden bit restored and shift = exponent - 1075, a shift from 0 to 62 moves the significand left with no rounding. The result keeps its low 64 bits. `overflow_o` is raised (when enabled) exactly when set significand bits are lost above bit 63.
- R6: A shift of 63 or more gives result 0 with no flag raised.
- R7: A negative shift truncates the significand toward zero before rounding. When reporting is enabled, `inexact_o` is raised whenever any discarded bit is set.
- R8: Mode 0 (nearest-even) adds one to the magnitude when the discarded part is above one half. It adds the magnitude's LSB when the discarded part is exactly one half.
- R9: Mode 3 (toward zero) never adjusts the magnitude. Mode 2 (up) adds one to the magnitude of a positive inexact value. Mode 1 (down) adds one to the magnitude of a negative inexact value.
- R10: When the sign bit (bit 63) is set, the final magnitude is negated modulo 2^64.
- R11: With `report_en_i` at 0, `overflow_o` and `inexact_o` stay low and the result is unchanged.
- R12: At most one of the three flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a conversion of the current inputs |
| operand_i | input | 64 | binary64 operand |
| rmode_i | input | 2 | 0 nearest-even, 1 down, 2 up, 3 toward zero |
| report_en_i | input | 1 | Enables the overflow and inexact flags |
| result_o | output | 64 | Wrapped two's-complement result |
| valid_o | output | 1 | Result and flags are new this cycle |
| invalid_o | output | 1 | Operand was a NaN |
| overflow_o | output | 1 | Infinity, or magnitude bits lost above bit 63 |
| inexact_o | output | 1 | Fraction bits were discarded |

## Verification
The assertions check the timing contract on every cycle: the valid pulse follows start by one cycle and the outputs hold between starts. They also check that flags are mutually exclusive, that a NaN always yields zero, that a disabled report keeps overflow and inexact low, and that a zero operand never raises a flag. The arithmetic itself can only be shown by the bench's directed scenarios. These cover ties to even, each rounding direction on both signs, wrap-around above 2^63, huge and tiny exponents, and subnormals.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_DOWN      = 2'd1,
        RM_UP        = 2'd2,
        RM_ZERO      = 2'd3
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic inexact;
    } flags_t;

endpackage

// File: rtl/dbl2int_align.sv
module dbl2int_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic [EXP_W+FRAC_W:0] operand_i,
    output logic [INT_W-1:0]      mag_o,
    output logic [INT_W-1:0]      rnd_o,
    output logic                  sign_o,
    output logic                  nan_o,
    output logic                  inf_o,
    output logic                  lost_o
);
    localparam int MANT_W     = FRAC_W + 1;
    localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
    localparam int SHIFT_BASE = BIAS + FRAC_W;
    localparam int SW         = EXP_W + 2;
    localparam int SH_W       = $clog2(INT_W);

    logic [EXP_W-1:0]            exp_f;
    logic [FRAC_W-1:0]           frac_f;
    logic [INT_W-1:0]            mant_ext;
    logic signed [SW-1:0]        sh;
    logic signed [SW-1:0]        nsh;
    logic [INT_W+MANT_W-1:0]     wide_left;
    logic [2*INT_W-1:0]          pair_right;

    assign sign_o = operand_i[EXP_W+FRAC_W];
    assign exp_f  = operand_i[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_f = operand_i[FRAC_W-1:0];

    always_comb begin
        mag_o      = '0;
        rnd_o      = '0;
        nan_o      = 1'b0;
        inf_o      = 1'b0;
        lost_o     = 1'b0;
        mant_ext   = INT_W'({1'b1, frac_f});
        sh         = $signed({2'b00, exp_f}) - SW'(SHIFT_BASE);
        nsh        = -sh;
        wide_left  = '0;
        pair_right = '0;
        if (exp_f == '0) begin
            if (frac_f != '0) begin
                rnd_o = INT_W'(1);
            end
        end else if (exp_f == '1) begin
            nan_o = (frac_f != '0);
            inf_o = (frac_f == '0);
        end else if (sh >= 0) begin
            if (sh < SW'(INT_W - 1)) begin
                wide_left = {{MANT_W{1'b0}}, mant_ext} << sh[SH_W-1:0];
                mag_o     = wide_left[INT_W-1:0];
                lost_o    = |wide_left[INT_W+MANT_W-1:INT_W];
            end
        end else begin
            if (nsh < SW'(INT_W - 1)) begin
                pair_right = {mant_ext, {INT_W{1'b0}}} >> nsh[SH_W-1:0];
                mag_o      = pair_right[2*INT_W-1:INT_W];
                rnd_o      = pair_right[INT_W-1:0];
            end else begin
                rnd_o = INT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dbl2int_round.sv
module dbl2int_round
    import dbl2int_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic [INT_W-1:0] mag_i,
    input  logic [INT_W-1:0] rnd_i,
    input  logic             sign_i,
    input  rmode_e           rmode_i,
    output logic [INT_W-1:0] result_o
);
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W-1:0] bump;
    logic [INT_W-1:0] rounded;

    always_comb begin
        bump = '0;
        if (rnd_i != '0) begin
            unique case (rmode_i)
                RM_NEAR_EVEN: begin
                    if (rnd_i == HALF)     bump = INT_W'(mag_i[0]);
                    else if (rnd_i > HALF) bump = INT_W'(1);
                end
                RM_UP:   bump = INT_W'(!sign_i);
                RM_DOWN: bump = INT_W'(sign_i);
                default: bump = '0;
            endcase
        end
        rounded  = mag_i + bump;
        result_o = sign_i ? -rounded : rounded;
    end

endmodule

// File: rtl/dbl2int_conv.sv
module dbl2int_conv
    import dbl2int_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [EXP_W+FRAC_W:0] operand_i,
    input  logic [1:0]            rmode_i,
    input  logic                  report_en_i,
    output logic [INT_W-1:0]      result_o,
    output logic                  valid_o,
    output logic                  invalid_o,
    output logic                  overflow_o,
    output logic                  inexact_o
);
    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] res;
        flags_t           flags;
    } state_t;

    state_t state_d, state_q;

    logic [INT_W-1:0] mag, rnd, res_c;
    logic             sign, nan, inf, lost;

    dbl2int_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) align_i (
        .operand_i (operand_i),
        .mag_o     (mag),
        .rnd_o     (rnd),
        .sign_o    (sign),
        .nan_o     (nan),
        .inf_o     (inf),
        .lost_o    (lost)
    );

    dbl2int_round #(.INT_W(INT_W)) round_i (
        .mag_i    (mag),
        .rnd_i    (rnd),
        .sign_i   (sign),
        .rmode_i  (rmode_e'(rmode_i)),
        .result_o (res_c)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = start_i;
        if (start_i) begin
            state_d.res            = res_c;
            state_d.flags.invalid  = nan;
            state_d.flags.overflow = report_en_i && (inf || lost);
            state_d.flags.inexact  = report_en_i && (rnd != '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign result_o   = state_q.res;
    assign valid_o    = state_q.valid;
    assign invalid_o  = state_q.flags.invalid;
    assign overflow_o = state_q.flags.overflow;
    assign inexact_o  = state_q.flags.inexact;

    p_valid_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> valid_o);
    p_no_spurious_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !valid_o);
    p_hold_between_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ($stable(result_o) && $stable({invalid_o, overflow_o, inexact_o})));
    p_zero_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && operand_i[EXP_W+FRAC_W-1:0] == '0) |=>
            (result_o == '0 && !invalid_o && !overflow_o && !inexact_o));
    p_nan_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && invalid_o) |-> (result_o == '0));
    p_no_report_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !report_en_i) |=> (!overflow_o && !inexact_o));
    p_flags_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({invalid_o, overflow_o, inexact_o}));

endmodule

// File: tb/dbl2int_conv_tb.sv
module dbl2int_conv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op = '0;
    logic [1:0]  rm = '0;
    logic        ren = 1'b0;
    logic [63:0] res;
    logic        vld, inv, ovf, inx;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbl2int_conv dut_i (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .operand_i (op),
        .rmode_i (rm), .report_en_i (ren), .result_o (res), .valid_o (vld),
        .invalid_o (inv), .overflow_o (ovf), .inexact_o (inx)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Launch one conversion and compare the cycle-after outputs.
    task automatic conv(string req, logic [63:0] a, logic [1:0] mode, logic en,
                        logic [63:0] e_res, logic e_inv, logic e_ovf, logic e_inx);
        @(negedge clk);
        op = a; rm = mode; ren = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " valid"}, 64'(vld), 64'd1);
        check({req, " result"}, res, e_res);
        check({req, " flags"}, 64'({inv, ovf, inx}), 64'({e_inv, e_ovf, e_inx}));
    endtask

    task automatic t_reset;
        check("R1 reset valid", 64'(vld), 64'd0);
        check("R1 reset result", res, 64'd0);
        check("R1 reset flags", 64'({inv, ovf, inx}), 64'd0);
    endtask

    task automatic t_zero;
        conv("R2 +0", 64'h0000000000000000, 2'd2, 1'b1, 64'd0, 0, 0, 0);
        conv("R2 -0", 64'h8000000000000000, 2'd1, 1'b1, 64'd0, 0, 0, 0);
    endtask

    task automatic t_special;
        conv("R3 nan", 64'h7FF8000000000000, 2'd0, 1'b1, 64'd0, 1, 0, 0);
        conv("R3 nan noreport", 64'h7FF0000000000001, 2'd0, 1'b0, 64'd0, 1, 0, 0);
        conv("R3 +inf", 64'h7FF0000000000000, 2'd0, 1'b1, 64'd0, 0, 1, 0);
        conv("R3 -inf", 64'hFFF0000000000000, 2'd3, 1'b1, 64'd0, 0, 1, 0);
        conv("R3 R11 inf noreport", 64'h7FF0000000000000, 2'd0, 1'b0, 64'd0, 0, 0, 0);
    endtask

    task automatic t_subnormal;
        conv("R4 sub near", 64'h0000000000000001, 2'd0, 1'b1, 64'd0, 0, 0, 1);
        conv("R4 sub up", 64'h0000000000000001, 2'd2, 1'b1, 64'd1, 0, 0, 1);
        conv("R4 neg sub down", 64'h8000000000000001, 2'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 0, 0, 1);
        conv("R4 neg sub up", 64'h8000000000000001, 2'd2, 1'b1, 64'd0, 0, 0, 1);
    endtask

    task automatic t_large;
        conv("R5 2^52+1", 64'h4330000000000001, 2'd0, 1'b1, 64'h0010000000000001, 0, 0, 0);
        conv("R5 2^63", 64'h43E0000000000000, 2'd0, 1'b1, 64'h8000000000000000, 0, 0, 0);
        conv("R5 2^64 wrap", 64'h43F0000000000000, 2'd0, 1'b1, 64'd0, 0, 1, 0);
        conv("R5 1.5*2^64", 64'h43F8000000000000, 2'd0, 1'b1, 64'h8000000000000000, 0, 1, 0);
        conv("R5 R10 -1.5*2^64", 64'hC3F8000000000000, 2'd0, 1'b1, 64'h8000000000000000, 0, 1, 0);
        conv("R5 R11 wrap noreport", 64'h43F0000000000000, 2'd0, 1'b0, 64'd0, 0, 0, 0);
        conv("R6 2^200", 64'h4C70000000000000, 2'd0, 1'b1, 64'd0, 0, 0, 0);
    endtask

    task automatic t_fraction;
        conv("R7 1.0 exact", 64'h3FF0000000000000, 2'd0, 1'b1, 64'd1, 0, 0, 0);
        conv("R7 2.75 rz", 64'h4006000000000000, 2'd3, 1'b1, 64'd2, 0, 0, 1);
        conv("R7 tiny up", 64'h39B0000000000000, 2'd2, 1'b1, 64'd1, 0, 0, 1);
        conv("R7 R11 2.5 noreport", 64'h4004000000000000, 2'd0, 1'b0, 64'd2, 0, 0, 0);
    endtask

    task automatic t_nearest;
        conv("R8 2.5 tie", 64'h4004000000000000, 2'd0, 1'b1, 64'd2, 0, 0, 1);
        conv("R8 3.5 tie", 64'h400C000000000000, 2'd0, 1'b1, 64'd4, 0, 0, 1);
        conv("R8 2.75 above", 64'h4006000000000000, 2'd0, 1'b1, 64'd3, 0, 0, 1);
        conv("R8 0.5 tie", 64'h3FE0000000000000, 2'd0, 1'b1, 64'd0, 0, 0, 1);
        conv("R8 0.75", 64'h3FE8000000000000, 2'd0, 1'b1, 64'd1, 0, 0, 1);
        conv("R8 R10 -2.5 tie", 64'hC004000000000000, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1);
    endtask

    task automatic t_directed;
        conv("R9 2.5 down", 64'h4004000000000000, 2'd1, 1'b1, 64'd2, 0, 0, 1);
        conv("R9 2.5 up", 64'h4004000000000000, 2'd2, 1'b1, 64'd3, 0, 0, 1);
        conv("R9 -2.5 down", 64'hC004000000000000, 2'd1, 1'b1, 64'hFFFFFFFFFFFFFFFD, 0, 0, 1);
        conv("R9 -2.5 up", 64'hC004000000000000, 2'd2, 1'b1, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1);
        conv("R9 -2.5 rz", 64'hC004000000000000, 2'd3, 1'b1, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1);
        conv("R10 -5.0", 64'hC014000000000000, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFB, 0, 0, 0);
    endtask

    task automatic t_hold;
        conv("R1 hold setup", 64'h4006000000000000, 2'd0, 1'b1, 64'd3, 0, 0, 1);
        @(negedge clk);
        op = 64'h7FF8000000000000; rm = 2'd1; ren = 1'b0;
        @(negedge clk);
        check("R1 no valid", 64'(vld), 64'd0);
        check("R1 hold result", res, 64'd3);
        check("R1 hold flags", 64'({inv, ovf, inx}), 64'b001);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_special();
        t_subnormal();
        t_large();
        t_fraction();
        t_nearest();
        t_directed();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule